// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Model

This block is a synthesizable, cycle-level model of a small dynamic memory chip. Its storage is a square grid of supercells, each `WIDTH` bits wide. The default grid is 4 rows by 4 columns of 8-bit supercells, which gives 128 bits in total.

A controller reaches any supercell through one narrow address bus, in two phases:

1. It places a row index on the address pins and asserts the row strobe. The whole row is copied into an internal row buffer.
2. It places a column index on the same pins and asserts the column strobe. The chosen supercell in the buffer is then either driven out on the read data bus or overwritten from the write data bus.

In the cycle after the column access, the complete buffer is written back into its array row. That write-back closes the row and also refreshes it.

A small refresh sequencer runs alongside the external path. A timer spaces out refresh requests so that, over one refresh period, every row receives an internal open and write-back in round-robin order. The sequencer uses a buffer of its own. It never starts while an external row is open or being written back.

Top module: `muxaddr_dram`

## Requirements
- R1: Every supercell of the grid (row index 0..3, column index 0..3 by default) stores the last value written to it and returns that value on a later read.
- R2: A row strobe sampled while idle opens the row named by `addr`. A column strobe with `writeEn`=0 sampled on the next edge makes `dataOut` carry the selected supercell, with `dataOe`=1, on the cycle after that edge only. `dataOe` is 0 on every other cycle.
- R3: A column strobe sampled with `writeEn`=1 loads `dataIn` into the selected supercell of the row buffer, and `dataOe` stays 0 for that access.
- R4: The cycle after any column access writes the whole row buffer back to the open array row and closes the row. The other supercells of that row keep their values.
- R5: A column strobe sampled while no row is open is ignored and leaves every supercell unchanged. `protoErr` is 1 for exactly the following cycle, and `dataOe` stays 0.
- R6: A row strobe sampled while a row is open or being written back is ignored and raises `protoErr` for the following cycle. The next column access still uses the row that was already open.
- R7: The refresh sequencer writes back every row at least once within `REF_PERIOD` cycles, plus a few cycles of deferral. Refresh never changes stored data.
- R8: After reset, `dataOe` and `protoErr` are 0 and no row is open. Array contents are left undefined by reset.
- R9: A refresh row-open never starts while an external row is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowStrobe | input | 1 | Row phase qualifier for `addr` |
| colStrobe | input | 1 | Column phase qualifier for `addr` |
| writeEn | input | 1 | Sampled with `colStrobe`: 1 = write, 0 = read |
| addr | input | ROW_BITS (2) | Multiplexed row/column index |
| dataIn | input | WIDTH (8) | Write data |
| dataOut | output | WIDTH (8) | Read data, valid when `dataOe` is 1 |
| dataOe | output | 1 | Read data bus drive enable |
| protoErr | output | 1 | One-cycle protocol error pulse |

## Verification
The main function is exercised in three ways:

- **Two full sweeps.** Each writes all sixteen supercells and then reads them back. The patterns are arithmetic in row and column: the first increasing, the second inverted and written in reverse order. This separates wrong address decoding, crossed rows and columns, and stale buffer contents.
- **Single-supercell update.** One supercell is rewritten and then its whole row is read back. This shows whether the write-back carries the full buffer or only the touched column.
- **Protocol misuse.** A stray column strobe with write enabled must leave its target column untouched in every row. A stray row strobe during an open row must not redirect the following column read.

A long idle stretch followed by a full read-back confirms that refresh activity leaves stored data intact.

// File: rtl/muxaddr_dram_pkg.sv
package muxaddr_dram_pkg;

  // Strobes from control to datapath, one per datapath action.
  typedef struct packed {
    logic loadRow;    // copy addressed array row into row buffer
    logic colRead;    // drive selected buffer supercell on read bus
    logic colWrite;   // load dataIn into selected buffer supercell
    logic writeBack;  // store row buffer into open array row
    logic refOpen;    // copy refresh row into refresh buffer
    logic refWb;      // store refresh buffer back into refresh row
  } dramStrobes_t;

  typedef enum logic [1:0] {
    EXT_IDLE = 2'd0,
    EXT_OPEN = 2'd1,
    EXT_WB   = 2'd2
  } extState_t;

  typedef enum logic {
    REF_IDLE = 1'b0,
    REF_WB   = 1'b1
  } refState_t;

endpackage

// File: rtl/muxaddr_dram_ctrl.sv
module muxaddr_dram_ctrl
  import muxaddr_dram_pkg::*;
#(
  parameter int ROW_BITS   = 2,
  parameter int REF_PERIOD = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rowStrobe,
  input  logic                colStrobe,
  input  logic                writeEn,
  input  logic [ROW_BITS-1:0] addr,
  output dramStrobes_t        stb,
  output logic [ROW_BITS-1:0] openRow,
  output logic [ROW_BITS-1:0] refRow,
  output logic                extOpen,
  output logic                protoErr
);

  localparam int ROWS         = 1 << ROW_BITS;
  localparam int REF_INTERVAL = (REF_PERIOD / ROWS) < 2 ? 2 : (REF_PERIOD / ROWS);
  localparam int TMR_W        = $clog2(REF_INTERVAL);

  extState_t         extState, extNext;
  refState_t         refState;
  logic              refPending;
  logic              refStart;
  logic              tmrWrap;
  logic              errNext;
  logic [TMR_W-1:0]  refTimer;

  // External access sequencing: row phase, column phase, write-back.
  always_comb begin
    stb     = '0;
    extNext = extState;
    case (extState)
      EXT_IDLE: begin
        if (rowStrobe) begin
          stb.loadRow = 1'b1;
          extNext     = EXT_OPEN;
        end
      end
      EXT_OPEN: begin
        if (colStrobe) begin
          stb.colWrite = writeEn;
          stb.colRead  = !writeEn;
          extNext      = EXT_WB;
        end
      end
      EXT_WB: begin
        stb.writeBack = 1'b1;
        extNext       = EXT_IDLE;
      end
      default: extNext = EXT_IDLE;
    endcase
    stb.refOpen = refStart;
    stb.refWb   = (refState == REF_WB);
  end

  assign refStart = refPending && (extState == EXT_IDLE) && (refState == REF_IDLE);
  assign tmrWrap  = (refTimer == TMR_W'(REF_INTERVAL - 1));
  assign errNext  = (colStrobe && (extState != EXT_OPEN)) ||
                    (rowStrobe && (extState != EXT_IDLE));
  assign extOpen  = (extState == EXT_OPEN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extState <= EXT_IDLE;
      openRow  <= '0;
      protoErr <= 1'b0;
    end else begin
      extState <= extNext;
      protoErr <= errNext;
      if (stb.loadRow) openRow <= addr;
    end
  end

  // Refresh pacing and round-robin row counter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refTimer   <= '0;
      refPending <= 1'b0;
      refState   <= REF_IDLE;
      refRow     <= '0;
    end else begin
      refTimer <= tmrWrap ? '0 : refTimer + 1'b1;
      if (refStart) refPending <= 1'b0;
      if (tmrWrap)  refPending <= 1'b1;
      case (refState)
        REF_IDLE: if (refStart) refState <= REF_WB;
        REF_WB: begin
          refState <= REF_IDLE;
          refRow   <= refRow + 1'b1;
        end
        default: refState <= REF_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/muxaddr_dram_datapath.sv
module muxaddr_dram_datapath
  import muxaddr_dram_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int WIDTH    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dramStrobes_t        stb,
  input  logic [ROW_BITS-1:0] addr,
  input  logic [ROW_BITS-1:0] openRow,
  input  logic [ROW_BITS-1:0] refRow,
  input  logic [WIDTH-1:0]    dataIn,
  output logic [WIDTH-1:0]    dataOut,
  output logic                dataOe
);

  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = ROWS;

  typedef logic [COLS-1:0][WIDTH-1:0] rowWord_t;

  rowWord_t cells [ROWS];
  rowWord_t rowBuf;
  rowWord_t refBuf;

  // Storage array: no reset, contents undefined until written.
  // External write-back is placed last so it wins on a shared row.
  always_ff @(posedge clk) begin
    if (stb.refWb)     cells[refRow]  <= refBuf;
    if (stb.writeBack) cells[openRow] <= rowBuf;
  end

  // Row buffer: whole-row load on the row phase, one supercell on a write.
  always_ff @(posedge clk) begin
    if (stb.loadRow) begin
      rowBuf <= cells[addr];
    end else if (stb.colWrite) begin
      for (int c = 0; c < COLS; c++) begin
        if (addr == ROW_BITS'(c)) rowBuf[c] <= dataIn;
      end
    end
  end

  // Private refresh buffer so refresh never disturbs the external row.
  always_ff @(posedge clk) begin
    if (stb.refOpen) refBuf <= cells[refRow];
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOe  <= 1'b0;
      dataOut <= '0;
    end else begin
      dataOe  <= stb.colRead;
      dataOut <= stb.colRead ? rowBuf[addr] : '0;
    end
  end

endmodule

// File: rtl/muxaddr_dram.sv
module muxaddr_dram
  import muxaddr_dram_pkg::*;
#(
  parameter int ROW_BITS   = 2,
  parameter int WIDTH      = 8,
  parameter int REF_PERIOD = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rowStrobe,
  input  logic                colStrobe,
  input  logic                writeEn,
  input  logic [ROW_BITS-1:0] addr,
  input  logic [WIDTH-1:0]    dataIn,
  output logic [WIDTH-1:0]    dataOut,
  output logic                dataOe,
  output logic                protoErr
);

  dramStrobes_t        stb;
  logic [ROW_BITS-1:0] openRow;
  logic [ROW_BITS-1:0] refRow;
  logic                extOpen;

  muxaddr_dram_ctrl #(
    .ROW_BITS  (ROW_BITS),
    .REF_PERIOD(REF_PERIOD)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rowStrobe(rowStrobe),
    .colStrobe(colStrobe),
    .writeEn  (writeEn),
    .addr     (addr),
    .stb      (stb),
    .openRow  (openRow),
    .refRow   (refRow),
    .extOpen  (extOpen),
    .protoErr (protoErr)
  );

  muxaddr_dram_datapath #(
    .ROW_BITS(ROW_BITS),
    .WIDTH   (WIDTH)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .addr   (addr),
    .openRow(openRow),
    .refRow (refRow),
    .dataIn (dataIn),
    .dataOut(dataOut),
    .dataOe (dataOe)
  );

endmodule

// File: rtl/muxaddr_dram_chk.sv
module muxaddr_dram_chk
  import muxaddr_dram_pkg::*;
#(
  parameter int ROW_BITS   = 2,
  parameter int REF_PERIOD = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                colStrobe,
  input logic                dataOe,
  input logic                protoErr,
  input dramStrobes_t        stb,
  input logic                extOpen,
  input logic [ROW_BITS-1:0] openRow,
  input logic [ROW_BITS-1:0] refRow
);

  localparam int ROWS      = 1 << ROW_BITS;
  localparam int AGE_LIMIT = REF_PERIOD + 8;
  localparam int AGE_W     = $clog2(AGE_LIMIT + 2) + 1;

  // R2: a read strobe yields output enable on the next cycle.
  a_r2_oe_after_read: assert property (@(posedge clk) disable iff (!rstN)
    stb.colRead |=> dataOe);

  // R2: output enable lasts a single cycle.
  a_r2_oe_single: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |=> !dataOe);

  // R3: a write never drives the read bus.
  a_r3_no_oe_on_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.colWrite |=> !dataOe);

  // R4: every column access is followed by the write-back.
  a_r4_wb_follows: assert property (@(posedge clk) disable iff (!rstN)
    (stb.colRead || stb.colWrite) |=> stb.writeBack);

  // R5: a column strobe with no open row raises the error and drives nothing.
  a_r5_col_without_row: assert property (@(posedge clk) disable iff (!rstN)
    (colStrobe && !extOpen) |=> (protoErr && !dataOe));

  // R9: refresh never opens while an external row is open.
  a_r9_ref_deferred: assert property (@(posedge clk) disable iff (!rstN)
    stb.refOpen |-> !extOpen);

  // R7: each row is written back within the refresh period plus slack.
  for (genvar r = 0; r < ROWS; r++) begin : g_age
    logic [AGE_W-1:0] age;
    logic             hit;
    assign hit = (stb.writeBack && openRow == ROW_BITS'(r)) ||
                 (stb.refWb && refRow == ROW_BITS'(r));
    always_ff @(posedge clk) begin
      if (!rstN)                              age <= '0;
      else if (hit)                           age <= '0;
      else if (age != AGE_W'(AGE_LIMIT + 1))  age <= age + 1'b1;
    end
    a_r7_row_refreshed: assert property (@(posedge clk) disable iff (!rstN)
      age <= AGE_W'(AGE_LIMIT));
  end

endmodule

bind muxaddr_dram muxaddr_dram_chk #(
  .ROW_BITS  (ROW_BITS),
  .REF_PERIOD(REF_PERIOD)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .colStrobe(colStrobe),
  .dataOe   (dataOe),
  .protoErr (protoErr),
  .stb      (stb),
  .extOpen  (extOpen),
  .openRow  (openRow),
  .refRow   (refRow)
);

// File: tb/muxaddr_dram_bench.sv
`timescale 1ns/1ps
module muxaddr_dram_bench;

  localparam int RB = 2;
  localparam int N  = 1 << RB;
  localparam int W  = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rowStrobe = 1'b0;
  logic          colStrobe = 1'b0;
  logic          writeEn = 1'b0;
  logic [RB-1:0] addr = '0;
  logic [W-1:0]  dataIn = '0;
  logic [W-1:0]  dataOut;
  logic          dataOe;
  logic          protoErr;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model [N][N];

  always #2.5 clk = ~clk;

  muxaddr_dram #(.ROW_BITS(RB), .WIDTH(W), .REF_PERIOD(64)) u_muxaddr_dram (
    .clk(clk), .rstN(rstN), .rowStrobe(rowStrobe), .colStrobe(colStrobe),
    .writeEn(writeEn), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .protoErr(protoErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; row, column, write-back cycles.
  task automatic access(input int r, input int c, input bit we,
                        input logic [W-1:0] wd, output logic [W-1:0] rd,
                        output bit oeCol, output bit oeAfter);
    rowStrobe = 1'b1; addr = RB'(r);
    @(negedge clk);
    rowStrobe = 1'b0; colStrobe = 1'b1; writeEn = we; addr = RB'(c); dataIn = wd;
    @(negedge clk);
    colStrobe = 1'b0; writeEn = 1'b0;
    rd = dataOut; oeCol = dataOe;
    @(negedge clk);
    oeAfter = dataOe;
  endtask

  task automatic writeCell(input int r, input int c, input logic [W-1:0] v);
    logic [W-1:0] rd; bit oe1, oe2;
    access(r, c, 1'b1, v, rd, oe1, oe2);
    model[r][c] = v;
    chk(!oe1 && !oe2, "R3 write leaves bus undriven", int'(oe1), 0);
  endtask

  task automatic readCell(input int r, input int c, input string tag);
    logic [W-1:0] rd; bit oe1, oe2;
    access(r, c, 1'b0, '0, rd, oe1, oe2);
    chk(oe1 && rd === model[r][c], tag, int'(rd), int'(model[r][c]));
    chk(!oe2, "R2 enable drops after one cycle", int'(oe2), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(dataOe === 1'b0, "R8 dataOe in reset", int'(dataOe), 0);
    chk(protoErr === 1'b0, "R8 protoErr in reset", int'(protoErr), 0);
    rstN = 1'b1;
    // R8/R5: no row open right after reset, a column strobe is flagged
    colStrobe = 1'b1; addr = 2'd0;
    @(negedge clk);
    colStrobe = 1'b0;
    chk(protoErr === 1'b1, "R8 no open row after reset", int'(protoErr), 1);
    chk(dataOe === 1'b0, "R8 no read after reset", int'(dataOe), 0);
    @(negedge clk);

    // R1/R3: first sweep, increasing pattern
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        writeCell(r, c, W'(r * 40 + c * 9 + 3));
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        readCell(r, c, "R1 R2 sweep one readback");

    // R1: second sweep, inverted pattern written in reverse order
    for (int r = N - 1; r >= 0; r--)
      for (int c = N - 1; c >= 0; c--)
        writeCell(r, c, ~W'(r * 17 + c * 70 + 5));
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        readCell(r, c, "R1 sweep two readback");

    // R4: single supercell update keeps the rest of the row
    writeCell(2, 1, 8'h5A);
    for (int c = 0; c < N; c++) readCell(2, c, "R4 row kept after write-back");

    // R5: stray column write without open row is ignored
    colStrobe = 1'b1; writeEn = 1'b1; addr = 2'd3; dataIn = 8'hAA;
    @(negedge clk);
    colStrobe = 1'b0; writeEn = 1'b0;
    chk(protoErr === 1'b1, "R5 error pulse", int'(protoErr), 1);
    chk(dataOe === 1'b0, "R5 no drive", int'(dataOe), 0);
    @(negedge clk);
    chk(protoErr === 1'b0, "R5 error lasts one cycle", int'(protoErr), 0);
    for (int r = 0; r < N; r++) readCell(r, 3, "R5 target column unchanged");

    // R6: second row strobe while open is ignored
    begin
      logic [W-1:0] rd;
      rowStrobe = 1'b1; addr = 2'd1;
      @(negedge clk);
      addr = 2'd3;
      @(negedge clk);
      rowStrobe = 1'b0;
      chk(protoErr === 1'b1, "R6 stray row strobe flagged", int'(protoErr), 1);
      colStrobe = 1'b1; writeEn = 1'b0; addr = 2'd2;
      @(negedge clk);
      colStrobe = 1'b0;
      rd = dataOut;
      chk(dataOe && rd === model[1][2], "R6 open row kept", int'(rd), int'(model[1][2]));
      @(negedge clk);
    end

    // R7: long idle stretch with refresh running, then full readback
    repeat (400) @(negedge clk);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        readCell(r, c, "R7 data kept across refresh");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule